// File: doc/BRIEF.md
# Dual-Thread Branch Direction Predictor

This block guesses whether a branch will be taken, for a core that runs two hardware threads. Each thread owns a private direction table of 4096 two-bit saturating counters. Every counter has a "seen" flag that reset clears. A lookup names the thread, the word address of the branch, whether its target lies behind it and whether it is unconditional. One cycle later the block presents a taken or not-taken guess.

A branch whose table entry has never been trained gets a fixed guess: a backward target is predicted taken and a forward target not taken. When the pipeline resolves a branch, it reports the thread, the word address and the real outcome on the training port. The first report places the entry in the weak state of the real direction. Later reports step the counter up or down, and it stops at the two ends. From then on, lookups of that entry follow the counter's upper bit. Target address generation and recovery from a wrong guess are the job of other blocks.

Per entry, the counter is a four-state machine: STRONG_NT (00), WEAK_NT (01), WEAK_T (10) and STRONG_T (11).
- A taken outcome moves it one step toward STRONG_T. A not-taken outcome moves it one step toward STRONG_NT.
- STRONG_T stays put on taken. STRONG_NT stays put on not-taken.
- An untrained entry jumps straight to WEAK_T on a taken outcome, or to WEAK_NT on a not-taken one.

The output register is a three-state machine:
- PRED_IDLE means no lookup happened in the previous cycle.
- PRED_TAKEN and PRED_NOT_TAKEN hold the guess for a lookup made in the previous cycle.

Each cycle the output register moves to the state chosen by the current lookup class:
- LK_NONE: no lookup.
- LK_UNCOND: an unconditional branch.
- LK_COLD: an untrained entry.
- LK_WARM: a trained entry.

Top module: `bhp_predictor`

## Requirements
- R1: While rst_n is low, pred_valid is 0. After reset, every entry of both threads is untrained.
- R2: pred_valid is 1 in exactly the cycle after a cycle with lk_valid high. pred_taken is 0 whenever pred_valid is 0.
- R3: An unconditional lookup (lk_uncond=1) is predicted taken, whatever the table holds.
- R4: A conditional lookup of an untrained entry is predicted taken when lk_backward=1 and not taken when lk_backward=0.
- R5: The first training of an entry sets it to WEAK_T (10) when up_taken=1, or to WEAK_NT (01) when up_taken=0. From then on, conditional lookups of it predict taken exactly when counter bit 1 is 1, whatever lk_backward is.
- R6: Each later training adds 1 on taken and subtracts 1 on not-taken, saturating at 00 and at 11.
- R7: The table index is the 12 word-address bits [13:2]. Training one index leaves every other index unchanged, including the other entries that share its storage row, and including index 0 and index 4095.
- R8: Thread 0 and thread 1 (lk_thread/up_thread = 0 or 1) have separate tables. Training one thread never changes the other thread's predictions.
- R9: When a lookup and a training hit the same entry in the same cycle, the lookup returns the prediction from before the training. The training applies to later lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_thread | input | THREAD_W | Thread of the lookup |
| lk_word_addr | input | IDX_W (bits IDX_W+1:2) | Word address of the branch being looked up |
| lk_backward | input | 1 | Branch target lies below the branch address |
| lk_uncond | input | 1 | Branch is unconditional |
| up_valid | input | 1 | Training request this cycle |
| up_thread | input | THREAD_W | Thread of the resolved branch |
| up_word_addr | input | IDX_W (bits IDX_W+1:2) | Word address of the resolved branch |
| up_taken | input | 1 | Resolved outcome, 1 = taken |
| pred_valid | output | 1 | A prediction is presented this cycle |
| pred_taken | output | 1 | Predicted direction, 1 = taken |

## Verification
The assertions check four things on every cycle:
- the one-cycle timing of pred_valid and the quiet output between lookups;
- the forced taken guess for unconditional branches;
- the static backward/forward rule for as long as no training has been seen since reset.

Only the bench scenarios can show the behaviours that depend on stored history:
- that training starts in the weak state of the real direction;
- that the counter saturates at both ends;
- that neighbouring entries in a packed row and the other thread stay untouched;
- that a same-cycle lookup and training return the old guess.

// File: rtl/bhp_pkg.sv
package bhp_pkg;

    localparam int CTR_W = 2;

    // Per-entry saturating counter states; bit 1 is the predicted direction.
    typedef enum logic [CTR_W-1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_state_e;

    // Output register states.
    typedef enum logic [1:0] {
        PRED_IDLE      = 2'b00,
        PRED_TAKEN     = 2'b01,
        PRED_NOT_TAKEN = 2'b10
    } pred_state_e;

    // Class of the lookup presented in the current cycle.
    typedef enum logic [1:0] {
        LK_NONE   = 2'b00,
        LK_UNCOND = 2'b01,
        LK_COLD   = 2'b10,
        LK_WARM   = 2'b11
    } lk_class_e;

endpackage

// File: rtl/bhp_ctr_next.sv
module bhp_ctr_next
    import bhp_pkg::*;
(
    input  ctr_state_e cur_state,
    input  logic       entry_seen,
    input  logic       outcome_taken,
    output ctr_state_e nxt_state
);

    always_comb begin
        nxt_state = cur_state;
        if (!entry_seen) begin
            // First training: weak state in the real direction.
            nxt_state = outcome_taken ? CTR_WEAK_T : CTR_WEAK_NT;
        end else begin
            unique case (cur_state)
                CTR_STRONG_NT: nxt_state = outcome_taken ? CTR_WEAK_NT  : CTR_STRONG_NT;
                CTR_WEAK_NT:   nxt_state = outcome_taken ? CTR_WEAK_T   : CTR_STRONG_NT;
                CTR_WEAK_T:    nxt_state = outcome_taken ? CTR_STRONG_T : CTR_WEAK_NT;
                CTR_STRONG_T:  nxt_state = outcome_taken ? CTR_STRONG_T : CTR_WEAK_T;
            endcase
        end
    end

endmodule

// File: rtl/bhp_bank.sv
module bhp_bank
    import bhp_pkg::*;
#(
    parameter int IDX_W  = 12,
    parameter int SLOT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_seen,
    output ctr_state_e       rd_state,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);

    localparam int ENTRIES = 1 << IDX_W;
    localparam int SLOTS   = 1 << SLOT_W;
    localparam int ROWS    = 1 << (IDX_W - SLOT_W);
    localparam int ROW_W   = SLOTS * CTR_W;
    localparam int ROW_AW  = IDX_W - SLOT_W;

    logic [ENTRIES-1:0] seen_q;
    logic [ROW_W-1:0]   rows_q [ROWS];

    logic [ROW_AW-1:0] rd_row_idx, wr_row_idx;
    logic [SLOT_W-1:0] rd_slot, wr_slot;
    logic [ROW_W-1:0]  rd_row, wr_row, wr_row_new;
    logic [CTR_W-1:0]  rd_slots [SLOTS];
    logic [CTR_W-1:0]  wr_slots [SLOTS];
    ctr_state_e        wr_cur, wr_nxt;

    assign rd_row_idx = rd_idx[IDX_W-1:SLOT_W];
    assign rd_slot    = rd_idx[SLOT_W-1:0];
    assign wr_row_idx = wr_idx[IDX_W-1:SLOT_W];
    assign wr_slot    = wr_idx[SLOT_W-1:0];

    assign rd_row = rows_q[rd_row_idx];
    assign wr_row = rows_q[wr_row_idx];

    // Unpack rows into slots and merge the trained slot back into its row.
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign rd_slots[g] = rd_row[g*CTR_W +: CTR_W];
        assign wr_slots[g] = wr_row[g*CTR_W +: CTR_W];
        assign wr_row_new[g*CTR_W +: CTR_W] =
            (wr_slot == SLOT_W'(g)) ? CTR_W'(wr_nxt) : wr_slots[g];
    end

    assign rd_seen  = seen_q[rd_idx];
    assign rd_state = ctr_state_e'(rd_slots[rd_slot]);
    assign wr_cur   = ctr_state_e'(wr_slots[wr_slot]);

    bhp_ctr_next u_next (
        .cur_state     (wr_cur),
        .entry_seen    (seen_q[wr_idx]),
        .outcome_taken (wr_taken),
        .nxt_state     (wr_nxt)
    );

    // Counter rows carry no reset; the seen flags mask them until trained.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            rows_q[wr_row_idx] <= wr_row_new;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (wr_en) begin
            seen_q[wr_idx] <= 1'b1;
        end
    end

endmodule

// File: rtl/bhp_predictor.sv
module bhp_predictor
    import bhp_pkg::*;
#(
    parameter int THREAD_W = 1,
    parameter int IDX_W    = 12,
    parameter int SLOT_W   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lk_valid,
    input  logic [THREAD_W-1:0] lk_thread,
    input  logic [IDX_W+1:2]    lk_word_addr,
    input  logic                lk_backward,
    input  logic                lk_uncond,
    input  logic                up_valid,
    input  logic [THREAD_W-1:0] up_thread,
    input  logic [IDX_W+1:2]    up_word_addr,
    input  logic                up_taken,
    output logic                pred_valid,
    output logic                pred_taken
);

    localparam int NUM_THREADS = 1 << THREAD_W;

    logic       bank_seen  [NUM_THREADS];
    ctr_state_e bank_state [NUM_THREADS];
    logic       sel_seen;
    ctr_state_e sel_state;
    lk_class_e   lk_class;
    pred_state_e pred_q, pred_nxt;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thread
        bhp_bank #(
            .IDX_W  (IDX_W),
            .SLOT_W (SLOT_W)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_idx   (lk_word_addr),
            .rd_seen  (bank_seen[t]),
            .rd_state (bank_state[t]),
            .wr_en    (up_valid && (up_thread == THREAD_W'(t))),
            .wr_idx   (up_word_addr),
            .wr_taken (up_taken)
        );
    end

    assign sel_seen  = bank_seen[lk_thread];
    assign sel_state = bank_state[lk_thread];

    always_comb begin
        if (!lk_valid)      lk_class = LK_NONE;
        else if (lk_uncond) lk_class = LK_UNCOND;
        else if (!sel_seen) lk_class = LK_COLD;
        else                lk_class = LK_WARM;
    end

    // Next-state selection.
    always_comb begin
        pred_nxt = PRED_IDLE;
        unique case (lk_class)
            LK_NONE:   pred_nxt = PRED_IDLE;
            LK_UNCOND: pred_nxt = PRED_TAKEN;
            LK_COLD:   pred_nxt = lk_backward  ? PRED_TAKEN : PRED_NOT_TAKEN;
            LK_WARM:   pred_nxt = sel_state[1] ? PRED_TAKEN : PRED_NOT_TAKEN;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pred_q <= PRED_IDLE;
        else        pred_q <= pred_nxt;
    end

    // Outputs.
    always_comb begin
        pred_valid = 1'b0;
        pred_taken = 1'b0;
        unique case (pred_q)
            PRED_IDLE:      begin pred_valid = 1'b0; pred_taken = 1'b0; end
            PRED_TAKEN:     begin pred_valid = 1'b1; pred_taken = 1'b1; end
            PRED_NOT_TAKEN: begin pred_valid = 1'b1; pred_taken = 1'b0; end
            default:        begin pred_valid = 1'b0; pred_taken = 1'b0; end
        endcase
    end

endmodule

// File: rtl/bhp_predictor_chk.sv
module bhp_predictor_chk (
    input logic clk,
    input logic rst_n,
    input logic lk_valid,
    input logic lk_backward,
    input logic lk_uncond,
    input logic up_valid,
    input logic pred_valid,
    input logic pred_taken
);

    logic any_train_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        any_train_q <= 1'b0;
        else if (up_valid) any_train_q <= 1'b1;
    end

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> pred_valid);

    assert_quiet_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!pred_valid && !pred_taken));

    assert_uncond_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_uncond) |=> pred_taken);

    assert_cold_static_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_uncond && !any_train_q) |=> (pred_taken == $past(lk_backward)));

endmodule

bind bhp_predictor bhp_predictor_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_valid    (lk_valid),
    .lk_backward (lk_backward),
    .lk_uncond   (lk_uncond),
    .up_valid    (up_valid),
    .pred_valid  (pred_valid),
    .pred_taken  (pred_taken)
);

// File: tb/bhp_predictor_tb_top.sv
`timescale 1ns/1ps
module bhp_predictor_tb_top;

    localparam int IDX_W = 12;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic             rst_n;
    logic             lk_valid, lk_backward, lk_uncond;
    logic [0:0]       lk_thread, up_thread;
    logic [IDX_W+1:2] lk_word_addr, up_word_addr;
    logic             up_valid, up_taken;
    logic             pred_valid, pred_taken;

    bhp_predictor dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .lk_valid     (lk_valid),
        .lk_thread    (lk_thread),
        .lk_word_addr (lk_word_addr),
        .lk_backward  (lk_backward),
        .lk_uncond    (lk_uncond),
        .up_valid     (up_valid),
        .up_thread    (up_thread),
        .up_word_addr (up_word_addr),
        .up_taken     (up_taken),
        .pred_valid   (pred_valid),
        .pred_taken   (pred_taken)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;
    bit    exp_q[$];
    string tag_q[$];

    task automatic check(bit ok, string tag, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Driver: present a lookup and push its expected result.
    task automatic lk(int tid, int idx, bit back, bit unc, bit exp, string tag);
        lk_valid     = 1'b1;
        lk_thread    = 1'(tid);
        lk_word_addr = IDX_W'(idx);
        lk_backward  = back;
        lk_uncond    = unc;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    task automatic up(int tid, int idx, bit taken);
        up_valid     = 1'b1;
        up_thread    = 1'(tid);
        up_word_addr = IDX_W'(idx);
        up_taken     = taken;
    endtask

    task automatic go();
        @(negedge clk);
        lk_valid = 1'b0;
        up_valid = 1'b0;
    endtask

    // Monitor: compare each prediction against the scoreboard.
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            if (pred_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected pred_valid", 1, 0);
                end else begin
                    bit    e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(pred_taken == e, t, int'(pred_taken), int'(e));
                end
            end else begin
                check(!pred_taken, "R2 pred_taken while idle", int'(pred_taken), 0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        lk_valid = 1'b0; lk_thread = '0; lk_word_addr = '0; lk_backward = 1'b0; lk_uncond = 1'b0;
        up_valid = 1'b0; up_thread = '0; up_word_addr = '0; up_taken = 1'b0;
        repeat (3) @(negedge clk);
        check(!pred_valid, "R1 reset pred_valid", int'(pred_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 / R3: untrained entry
        lk(0, 5, 0, 0, 0, "R4 cold forward");  go();
        lk(0, 5, 1, 0, 1, "R4 cold backward"); go();
        lk(0, 5, 0, 1, 1, "R3 uncond forward"); go();

        // R5: first training taken -> WEAK_T
        up(0, 5, 1); go();
        lk(0, 5, 0, 0, 1, "R5 first taken weak"); up(0, 5, 0); go();   // -> 01
        lk(0, 5, 1, 0, 0, "R5 history over backward rule"); go();

        // R6: low saturation
        up(0, 5, 0); go();   // 00
        up(0, 5, 0); go();   // stays 00
        up(0, 5, 1); go();   // 01
        lk(0, 5, 1, 0, 0, "R6 low saturation a"); go();
        up(0, 5, 1); go();   // 10
        lk(0, 5, 0, 0, 1, "R6 low saturation b"); go();

        // R6: high saturation
        up(0, 5, 1); go();   // 11
        up(0, 5, 1); go();   // stays 11
        up(0, 5, 0); go();   // 10
        lk(0, 5, 0, 0, 1, "R6 high saturation a"); go();
        up(0, 5, 0); go();   // 01
        lk(0, 5, 1, 0, 0, "R6 high saturation b"); go();

        // R5: first training not taken -> WEAK_NT
        up(0, 9, 0); go();
        lk(0, 9, 1, 0, 0, "R5 first not-taken weak"); go();
        up(0, 9, 1); go();
        lk(0, 9, 0, 0, 1, "R5 weak not-taken plus one"); go();

        // R7: row neighbours and index extremes
        lk(0, 4, 0, 0, 0, "R7 neighbour cold forward"); go();
        lk(0, 4, 1, 0, 1, "R7 neighbour cold backward"); go();
        up(0, 6, 1); go();
        lk(0, 5, 1, 0, 0, "R7 neighbour kept"); go();
        lk(0, 6, 0, 0, 1, "R7 trained slot"); go();
        up(0, 4095, 1); go();
        lk(0, 4095, 0, 0, 1, "R7 top index"); go();
        lk(0, 2047, 0, 0, 0, "R7 index msb distinct"); go();
        lk(0, 0, 0, 0, 0, "R7 index zero untouched"); go();

        // R8: thread isolation
        lk(1, 5, 1, 0, 1, "R8 thread1 cold"); go();
        up(1, 5, 0); go();
        lk(1, 5, 1, 0, 0, "R8 thread1 own history"); go();
        up(1, 6, 0); go();
        lk(0, 6, 0, 0, 1, "R8 thread0 unaffected"); go();
        lk(1, 5, 0, 1, 1, "R3 uncond over not-taken history"); go();

        // R9: same-cycle lookup and training
        lk(0, 20, 0, 0, 0, "R9 old prediction"); up(0, 20, 1); go();
        lk(0, 20, 0, 0, 1, "R9 training landed"); go();

        go(); go();
        check(exp_q.size() == 0, "R2 pending predictions", exp_q.size(), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule